// File: doc/BRIEF.md
# Regulator Fault and VID Supervisor

This block sequences faults and restarts for a multiphase voltage regulator controller. It receives digital flags from analog comparators: supply above the upper lockout threshold, supply below the lower lockout threshold, overcurrent, output in regulation, soft-start voltage above its power-good level, and soft-start voltage below its restart level. It also receives the processor voltage-identification (VID) code. From these it drives the error-amplifier enable, a soft-start request, a main fault latch, a VID fault latch and an active-high power-good output.

A VID code that signals a missing processor is treated as a fault only after it has stayed unchanged in its invalid form for a qualification window of 1.3 µs. This keeps dynamic code changes from tripping it. The response depends on a mode pin. In latching mode the controller shuts down until power-on reset, and invalid codes are masked while startup is in progress. In auto-restart mode only the main fault is raised, and soft-start begins again once the code is valid and the soft-start capacitor has discharged. The comparator flags and the code word pass through two-flop synchronizers. The mode pins are treated as static straps. All control pins are plain levels, and the block has no streaming interface.

Top module: `vr_fault_supervisor`

## Requirements
- R1: With `vr11_mode`=0, the code is invalid when bits 6..2 of `vid_code` are all 1. Bits 7, 1 and 0 have no effect on this test. Examples: 0x7C, 0x7F and 0xFC are invalid; 0x7B and 0x00 are valid.
- R2: With `vr11_mode`=1, the code is invalid when bits 7..1 are all 0 or all 1. Examples: 0x00, 0x01, 0xFE and 0xFF are invalid; 0x02, 0xFD and 0x7F are valid.
- R3: An invalid code raises a fault only after it has been present without a break for QUAL_CYCLES clock cycles, where QUAL_CYCLES = ceil(CLK_MHZ × QUAL_NS / 1000). The default is 325 cycles. A shorter burst of invalid code raises no fault.
- R4: With `vid_latch_mode`=1, a qualified invalid code sets both `vid_fault` and `main_fault`. Both stay set, even after the code becomes valid, until `por_n` is pulsed low.
- R5: With `vid_latch_mode`=1, invalid codes are ignored during startup. Startup runs from the cycle `main_fault` clears until `power_good` first goes high.
- R6: With `vid_latch_mode`=0, a qualified invalid code sets `main_fault` only. `vid_fault` stays 0.
- R7: With `vid_latch_mode`=0, `main_fault` clears only when the code is valid, `ss_discharged` is 1, and no other fault condition is present.
- R8: `supply_lo` sets `main_fault`. `main_fault` clears when `supply_hi` is 1 and no fault condition is present.
- R9: `ea_enable` is 0 while `main_fault` is set or while in undervoltage lockout. Lockout runs from reset, or from `supply_lo`, until `supply_hi` is seen. `ss_request` is the inverse of `main_fault`.
- R10: `power_good` is 1 only when `main_fault` is 0, `out_in_reg` is 1 and `ss_pg_ok` is 1.
- R11: `overcurrent` sets `main_fault`. In auto-restart mode, `main_fault` clears again once the overcurrent flag is gone.
- R12: While `por_n` is 0 and just after it is released: `main_fault`=1, `vid_fault`=0, `ea_enable`=0, `ss_request`=0 and `power_good`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_hi | input | 1 | Supply above the upper lockout threshold |
| supply_lo | input | 1 | Supply below the lower lockout threshold |
| overcurrent | input | 1 | Overcurrent comparator flag |
| out_in_reg | input | 1 | Output voltage in regulation |
| ss_pg_ok | input | 1 | Soft-start voltage above the power-good level |
| ss_discharged | input | 1 | Soft-start voltage below the restart level |
| vid_code | input | 8 | Voltage-identification code |
| vr11_mode | input | 1 | 1 selects 8-bit code rules, 0 selects 7-bit rules |
| vid_latch_mode | input | 1 | 1 latches off on an invalid code, 0 auto-restarts |
| ea_enable | output | 1 | Error-amplifier enable |
| ss_request | output | 1 | Soft-start request |
| vid_fault | output | 1 | VID fault latch |
| main_fault | output | 1 | Main fault latch |
| power_good | output | 1 | Power-good indication |

## Verification
The hardest situation to reach from the ports is the startup mask in latching mode. It needs an invalid code held for longer than the whole qualification window while startup is in progress, followed by the end of startup with the code still present. The stimulus holds `out_in_reg` low so that startup cannot end, applies an all-zero 8-bit code for more than 400 cycles, and checks that neither fault latch sets. It then raises the regulation and power-good flags and expects both latches to set within a few cycles, because the qualification counter is already full when the mask lifts. The same test then removes the code and confirms the fault stays set until power-on reset.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  parameter int VID_W = 8;

  typedef struct packed {
    logic supply_hi;
    logic supply_lo;
    logic oc;
    logic in_reg;
    logic ss_pg;
    logic ss_low;
  } flags_t;

  localparam int FLAGS_W = $bits(flags_t);
endpackage

// File: rtl/vrs_sync.sv
module vrs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/vrs_vid_check.sv
module vrs_vid_check #(
  parameter int VID_W       = 8,
  parameter int QUAL_CYCLES = 325
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid,
  input  logic             vr11,
  output logic             invalid,
  output logic             qualified
);
  localparam int CNT_W = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);
  localparam logic [VID_W-1:0] M10  = VID_W'(8'h7C);
  localparam logic [VID_W-1:0] M11  = VID_W'(8'hFE);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (vr11)
      invalid = ((vid & M11) == '0) || ((vid & M11) == M11);
    else
      invalid = ((vid & M10) == M10);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!invalid)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign qualified = invalid && (cnt == LAST);

  p_qual_needs_history_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qualified |-> $past(invalid));
  p_valid_clears_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !invalid |=> !qualified);
endmodule

// File: rtl/vrs_fault_core.sv
module vrs_fault_core
  import vrs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t fl,
  input  logic   vid_invalid,
  input  logic   vid_qual,
  input  logic   latch_mode,
  output logic   main_fault,
  output logic   vid_fault,
  output logic   uvlo,
  output logic   pgood
);
  logic startup;
  logic vid_trip;
  logic set_fault;
  logic clear_ok;

  assign pgood     = !main_fault && fl.in_reg && fl.ss_pg;
  assign vid_trip  = vid_qual && !(latch_mode && startup);
  assign set_fault = fl.supply_lo || fl.oc || vid_trip;
  assign clear_ok  = !set_fault && fl.supply_hi && fl.ss_low && !vid_fault
                     && !(vid_invalid && !latch_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_fault <= 1'b1;
      vid_fault  <= 1'b0;
      uvlo       <= 1'b1;
      startup    <= 1'b0;
    end else begin
      if (set_fault)
        main_fault <= 1'b1;
      else if (clear_ok)
        main_fault <= 1'b0;

      if (vid_trip && latch_mode)
        vid_fault <= 1'b1;

      if (fl.supply_lo)
        uvlo <= 1'b1;
      else if (fl.supply_hi)
        uvlo <= 1'b0;

      if (set_fault || pgood)
        startup <= 1'b0;
      else if (main_fault && clear_ok)
        startup <= 1'b1;
    end
  end

  p_latched_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vid_fault |=> (vid_fault && main_fault));
  p_auto_no_vid_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && !vid_fault) |=> !vid_fault);
  p_uv_sets_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fl.supply_lo |=> main_fault);
  p_oc_sets_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl.oc |=> main_fault);
  p_clear_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_fault) |-> $past(fl.supply_hi));
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vrs_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int QUAL_NS = 1300
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             supply_hi,
  input  logic             supply_lo,
  input  logic             overcurrent,
  input  logic             out_in_reg,
  input  logic             ss_pg_ok,
  input  logic             ss_discharged,
  input  logic [VID_W-1:0] vid_code,
  input  logic             vr11_mode,
  input  logic             vid_latch_mode,
  output logic             ea_enable,
  output logic             ss_request,
  output logic             vid_fault,
  output logic             main_fault,
  output logic             power_good
);
  localparam int QUAL_CYCLES = (CLK_MHZ * QUAL_NS + 999) / 1000;

  flags_t           raw_fl;
  flags_t           s_fl;
  logic [VID_W-1:0] s_vid;
  logic             invalid;
  logic             qualified;
  logic             uvlo;

  assign raw_fl = '{supply_hi: supply_hi, supply_lo: supply_lo, oc: overcurrent,
                    in_reg: out_in_reg, ss_pg: ss_pg_ok, ss_low: ss_discharged};

  vrs_sync #(.W(FLAGS_W)) u_flag_sync (
    .clk(clk), .rst_n(por_n), .d(raw_fl), .q(s_fl)
  );

  vrs_sync #(.W(VID_W)) u_vid_sync (
    .clk(clk), .rst_n(por_n), .d(vid_code), .q(s_vid)
  );

  vrs_vid_check #(.VID_W(VID_W), .QUAL_CYCLES(QUAL_CYCLES)) u_vid (
    .clk(clk), .rst_n(por_n), .vid(s_vid), .vr11(vr11_mode),
    .invalid(invalid), .qualified(qualified)
  );

  vrs_fault_core u_core (
    .clk(clk), .rst_n(por_n), .fl(s_fl), .vid_invalid(invalid),
    .vid_qual(qualified), .latch_mode(vid_latch_mode),
    .main_fault(main_fault), .vid_fault(vid_fault), .uvlo(uvlo),
    .pgood(power_good)
  );

  assign ea_enable  = !main_fault && !uvlo;
  assign ss_request = !main_fault;

  p_pgood_needs_no_fault_r10: assert property (@(posedge clk) disable iff (!por_n)
    power_good |-> (!main_fault && s_fl.in_reg));
  p_ea_off_in_lockout_r9: assert property (@(posedge clk) disable iff (!por_n)
    s_fl.supply_lo |=> !ea_enable);
endmodule

// File: tb/vr_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module vr_fault_supervisor_tb_top;
  localparam int QUAL = 325;
  localparam int NV = 11;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 8'h7C, 1'b1}, {1'b0, 8'h7F, 1'b1}, {1'b0, 8'hFC, 1'b1},
    {1'b0, 8'h7B, 1'b0}, {1'b0, 8'h00, 1'b0},
    {1'b1, 8'h00, 1'b1}, {1'b1, 8'h01, 1'b1}, {1'b1, 8'hFE, 1'b1},
    {1'b1, 8'hFF, 1'b1}, {1'b1, 8'h02, 1'b0}, {1'b1, 8'hFD, 1'b0}
  };

  logic clk = 0;
  logic por_n = 0;
  logic supply_hi = 0, supply_lo = 0, overcurrent = 0;
  logic out_in_reg = 0, ss_pg_ok = 0, ss_discharged = 1;
  logic [7:0] vid_code = 8'h40;
  logic vr11_mode = 0, vid_latch_mode = 0;
  logic ea_enable, ss_request, vid_fault, main_fault, power_good;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vr_fault_supervisor dut_i (
    .clk(clk), .por_n(por_n), .supply_hi(supply_hi), .supply_lo(supply_lo),
    .overcurrent(overcurrent), .out_in_reg(out_in_reg), .ss_pg_ok(ss_pg_ok),
    .ss_discharged(ss_discharged), .vid_code(vid_code), .vr11_mode(vr11_mode),
    .vid_latch_mode(vid_latch_mode), .ea_enable(ea_enable),
    .ss_request(ss_request), .vid_fault(vid_fault), .main_fault(main_fault),
    .power_good(power_good)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check("R12 main_fault at reset", main_fault, 1'b1);
    check("R12 vid_fault at reset", vid_fault, 1'b0);
    check("R12 ea_enable at reset", ea_enable, 1'b0);
    check("R12 ss_request at reset", ss_request, 1'b0);
    check("R12 power_good at reset", power_good, 1'b0);
    por_n = 1;
    wait_cyc(6);
    check("R9 ea off before supply_hi", ea_enable, 1'b0);
    supply_hi = 1;
    wait_cyc(6);
    check("R8 fault clears on supply_hi", main_fault, 1'b0);
    check("R9 ea on after supply_hi", ea_enable, 1'b1);
    check("R9 ss_request on", ss_request, 1'b1);
    check("R10 pgood low without regulation", power_good, 1'b0);
    out_in_reg = 1;
    wait_cyc(6);
    check("R10 pgood low without ss level", power_good, 1'b0);
    ss_pg_ok = 1;
    wait_cyc(6);
    check("R10 pgood high", power_good, 1'b1);

    // Vector walk, auto-restart mode: R1 / R2 decoding, R6 no VID latch
    for (int i = 0; i < NV; i++) begin
      vr11_mode = VEC[i][9];
      vid_code  = VEC[i][8:1];
      wait_cyc(QUAL + 10);
      check(VEC[i][9] ? "R2 vr11 decode" : "R1 vr10 decode", main_fault, VEC[i][0]);
      check("R6 vid_fault stays low", vid_fault, 1'b0);
      vid_code = 8'h40;
      wait_cyc(10);
      check("R7 restart after code removed", main_fault, 1'b0);
    end

    // R3: short burst, then full window
    vr11_mode = 1;
    vid_code = 8'hFF;
    wait_cyc(QUAL - 30);
    vid_code = 8'h40;
    wait_cyc(40);
    check("R3 short burst ignored", main_fault, 1'b0);
    vid_code = 8'hFF;
    wait_cyc(QUAL - 10);
    check("R3 no fault before window", main_fault, 1'b0);
    wait_cyc(20);
    check("R3 fault after window", main_fault, 1'b1);
    check("R10 pgood drops with fault", power_good, 1'b0);
    vid_code = 8'h40;
    wait_cyc(10);

    // R7: restart needs soft-start discharged and valid code
    ss_discharged = 0;
    wait_cyc(5);
    vid_code = 8'h00;
    wait_cyc(QUAL + 10);
    check("R7 fault on invalid code", main_fault, 1'b1);
    ss_discharged = 1;
    wait_cyc(20);
    check("R7 no restart while code invalid", main_fault, 1'b1);
    ss_discharged = 0;
    wait_cyc(5);
    vid_code = 8'h40;
    wait_cyc(50);
    check("R7 no restart before discharge", main_fault, 1'b1);
    ss_discharged = 1;
    wait_cyc(10);
    check("R7 restart after discharge", main_fault, 1'b0);
    check("R6 vid_fault low in auto mode", vid_fault, 1'b0);

    // R11: overcurrent
    overcurrent = 1;
    wait_cyc(5);
    check("R11 overcurrent sets fault", main_fault, 1'b1);
    check("R9 ea off on fault", ea_enable, 1'b0);
    overcurrent = 0;
    wait_cyc(6);
    check("R11 clears after overcurrent", main_fault, 1'b0);

    // R8 / R9: undervoltage
    supply_lo = 1;
    supply_hi = 0;
    wait_cyc(5);
    check("R8 supply_lo sets fault", main_fault, 1'b1);
    check("R9 ea off in lockout", ea_enable, 1'b0);
    supply_lo = 0;
    wait_cyc(10);
    check("R8 held until supply_hi", main_fault, 1'b1);
    supply_hi = 1;
    wait_cyc(6);
    check("R8 clears on supply_hi", main_fault, 1'b0);
    check("R9 ea back on", ea_enable, 1'b1);

    // R4 / R5: latching mode
    vid_latch_mode = 1;
    out_in_reg = 0;
    ss_pg_ok = 0;
    por_n = 0;
    wait_cyc(3);
    por_n = 1;
    wait_cyc(8);
    check("R5 startup begins", main_fault, 1'b0);
    vid_code = 8'h00;
    wait_cyc(QUAL + 80);
    check("R5 invalid masked in startup", main_fault, 1'b0);
    check("R5 no vid latch in startup", vid_fault, 1'b0);
    out_in_reg = 1;
    ss_pg_ok = 1;
    wait_cyc(10);
    check("R4 main fault after startup", main_fault, 1'b1);
    check("R4 vid fault latched", vid_fault, 1'b1);
    vid_code = 8'h40;
    wait_cyc(60);
    check("R4 stays off after code removed", main_fault, 1'b1);
    check("R4 vid_fault held", vid_fault, 1'b1);
    por_n = 0;
    wait_cyc(3);
    check("R12 por clears vid_fault", vid_fault, 1'b0);
    por_n = 1;
    wait_cyc(8);
    check("R4 restart after por", main_fault, 1'b0);
    check("R10 pgood after restart", power_good, 1'b1);

    done = 1;
    summary();
    $finish;
  end
endmodule